// File: doc/BRIEF.md
# Event Sampler with Coincidence Mode

This block watches two single-cycle strobes: an input event that may carry a data word, and a sampling event. An input event is remembered in a one-deep pending flag. On the next sampling event the block raises its output strobe, and the flag is then consumed. A sampling event that finds nothing pending gives no output. The output strobe is therefore always a thinned copy of the sampling strobe. It is combinational from the sampling strobe, so it appears in the same cycle as the sampling event that produced it.

A build-time mode parameter decides what happens when an input arrives in the same cycle as a sampling event. In weak mode that input is taken at once. In strict mode it is held back for the following sampling event, and an input that was already pending still fires in that cycle. Several inputs between two samples merge into one output. The data output carries the value of the most recent of them, and the earlier ones are lost.

Top module: `event_sampler`

## Requirements
- R1: `out_vld` is high only in cycles where `smp_vld` is high.
- R2: In weak mode (`MODE = ES_WEAK`), an input with `smp_vld` in the same cycle gives `out_vld` high in that same cycle, and `out_data` equals that cycle's `in_data`.
- R3: In strict mode (`MODE = ES_STRICT`), an input in the same cycle as `smp_vld` with nothing pending gives no output in that cycle. The next sampling event then fires with that input's data.
- R4: Several inputs between two sampling events give exactly one output, and its `out_data` is the value of the last of those inputs.
- R5: A sampling event with no pending input and no qualifying coincident input leaves `out_vld` low, and the next sampling event (with no input between) also stays low.
- R6: In strict mode, a sampling event that meets both a pending input and a coincident input fires with the pending input's data, and the next sampling event fires with the coincident input's data.
- R7: `out_data` is all zeros in every cycle where `out_vld` is low.
- R8: A synchronous active-low reset (`rst_n` low at a rising clock edge) clears the pending flag, so a later sampling event with no new input gives no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Input event strobe |
| in_data | input | DATA_W | Value carried by the input event |
| smp_vld | input | 1 | Sampling event strobe |
| out_vld | output | 1 | Sampled output event strobe |
| out_data | output | DATA_W | Last captured input value, zero when `out_vld` is low |

## Verification
Two functions can fall in the same cycle: capturing a new input and consuming the pending flag on a sampling event. The bench provokes this by raising both strobes together, once with nothing pending and once with an input already pending. Each case is run on a weak instance and a strict instance side by side. The output in that cycle and on the next sampling event is compared against the mode rule: weak takes the new value at once, and strict fires the older value and then the new one.

// File: rtl/es_pkg.sv
// Package: shared types for the event sampler.
// Assumes: nothing beyond IEEE 1800-2017.
package es_pkg;

    // Handling of an input that coincides with a sampling event.
    typedef enum logic {
        ES_WEAK   = 1'b0,   // coincident input is sampled in the same cycle
        ES_STRICT = 1'b1    // coincident input waits for the next sample
    } mode_e;

endpackage

// File: rtl/es_pending.sv
// Module: es_pending
// Holds the one-deep "input seen since last sample" flag.
// Assumes: strobes are synchronous to clk, and reset is synchronous, active low.
module es_pending
    import es_pkg::*;
#(
    parameter mode_e MODE = ES_WEAK
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_vld,
    input  logic smp_vld,
    output logic pend_q
);

    logic pend_d;

    // Next-state rule for the pending flag, chosen by the mode.
    generate
        if (MODE == ES_STRICT) begin : g_strict
            always_comb begin
                if (smp_vld) pend_d = in_vld;           // consume, re-arm on coincident input
                else         pend_d = pend_q | in_vld;
            end
        end else begin : g_weak
            always_comb begin
                if (smp_vld) pend_d = 1'b0;             // coincident input used at once
                else         pend_d = pend_q | in_vld;
            end
        end
    endgenerate

    // Flag register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= 1'b0;
        else        pend_q <= pend_d;
    end

    // R8: reset leaves the flag clear.
    p_reset_clear_r8: assert property (@(posedge clk) !rst_n |=> !pend_q);

    // R5: a sample with no coincident input leaves nothing pending.
    p_sample_drain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && !in_vld) |=> !pend_q);

    generate
        if (MODE == ES_STRICT) begin : g_chk_strict
            // R3: strict mode defers a coincident input to the next sample.
            p_strict_defer_r3: assert property (@(posedge clk) disable iff (!rst_n)
                (smp_vld && in_vld) |=> pend_q);
        end
    endgenerate

endmodule

// File: rtl/es_hold.sv
// Module: es_hold
// Keeps the value of the most recent input event.
// Assumes: in_data is meaningful only while in_vld is high.
module es_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    output logic [DATA_W-1:0] held_q
);

    // Capture register: the latest input overwrites any earlier one.
    always_ff @(posedge clk) begin
        if (!rst_n)      held_q <= '0;
        else if (in_vld) held_q <= in_data;
    end

    // R4: a captured input is what the register shows next cycle.
    p_capture_last_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (held_q == $past(in_data)));

endmodule

// File: rtl/es_fire.sv
// Module: es_fire
// Decides whether a sampling event fires and selects the output value.
// Assumes: pend_q and held_q come from es_pending and es_hold of the same mode.
module es_fire
    import es_pkg::*;
#(
    parameter int    DATA_W = 8,
    parameter mode_e MODE   = ES_WEAK
) (
    input  logic              pend_q,
    input  logic [DATA_W-1:0] held_q,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    input  logic              smp_vld,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data
);

    logic              hit;
    logic [DATA_W-1:0] pick;

    // Fire condition and value source, chosen by the mode.
    generate
        if (MODE == ES_STRICT) begin : g_strict
            always_comb begin
                hit  = smp_vld & pend_q;                 // only earlier inputs qualify
                pick = held_q;
            end
        end else begin : g_weak
            always_comb begin
                hit  = smp_vld & (pend_q | in_vld);      // coincident input qualifies
                pick = in_vld ? in_data : held_q;        // newest value wins
            end
        end
    endgenerate

    // Output gating: data is forced to zero while not valid.
    always_comb begin
        out_vld  = hit;
        out_data = hit ? pick : '0;
    end

endmodule

// File: rtl/event_sampler.sv
// Module: event_sampler (top)
// Samples an input event stream on a sampling strobe. One pending input
// at most, and surplus inputs between samples merge into the last one.
// Assumes: single clock, synchronous active-low reset, single-cycle strobes.
module event_sampler
    import es_pkg::*;
#(
    parameter int    DATA_W = 8,
    parameter mode_e MODE   = ES_WEAK
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_vld,
    input  logic [DATA_W-1:0] in_data,
    input  logic              smp_vld,
    output logic              out_vld,
    output logic [DATA_W-1:0] out_data
);

    logic              pend_q;
    logic [DATA_W-1:0] held_q;

    es_pending #(.MODE(MODE)) u_pend (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .smp_vld (smp_vld),
        .pend_q  (pend_q)
    );

    es_hold #(.DATA_W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (in_vld),
        .in_data (in_data),
        .held_q  (held_q)
    );

    es_fire #(.DATA_W(DATA_W), .MODE(MODE)) u_fire (
        .pend_q   (pend_q),
        .held_q   (held_q),
        .in_vld   (in_vld),
        .in_data  (in_data),
        .smp_vld  (smp_vld),
        .out_vld  (out_vld),
        .out_data (out_data)
    );

    // R1: output is a sub-sequence of sampling events.
    p_out_on_sample_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_vld |-> smp_vld);

    // R7: data is zero whenever the strobe is low.
    p_data_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !out_vld |-> (out_data == '0));

    generate
        if (MODE == ES_WEAK) begin : g_chk_weak
            // R2: weak mode fires at once on a coincident input.
            p_weak_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
                (smp_vld && in_vld) |-> (out_vld && out_data == in_data));
        end else begin : g_chk_strict
            // R6: a strict sample with a coincident input fires the next sample.
            p_strict_rearm_r6: assert property (@(posedge clk) disable iff (!rst_n)
                (smp_vld && in_vld) ##1 (smp_vld && !in_vld) |-> out_vld);
        end
    endgenerate

endmodule

// File: tb/sim_event_sampler.sv
// Bench for event_sampler: runs a weak and a strict instance side by side.
module sim_event_sampler;
    import es_pkg::*;

    localparam int DW = 8;
    localparam int NV = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_vld = 1'b0;
    logic [DW-1:0] in_data = '0;
    logic          smp_vld = 1'b0;
    logic          w_vld, s_vld;
    logic [DW-1:0] w_data, s_data;
    int            checks = 0;
    int            failures = 0;
    bit            done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    event_sampler #(.DATA_W(DW), .MODE(ES_WEAK)) u0 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
        .smp_vld(smp_vld), .out_vld(w_vld), .out_data(w_data));

    event_sampler #(.DATA_W(DW), .MODE(ES_STRICT)) u1 (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_data(in_data),
        .smp_vld(smp_vld), .out_vld(s_vld), .out_data(s_data));

    // {in_vld, in_data, smp_vld, weak_vld, weak_data, strict_vld, strict_data}
    localparam logic [27:0] VEC [NV] = '{
        {1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00},  // R5 empty sample
        {1'b1, 8'h11, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00},
        {1'b0, 8'h00, 1'b1, 1'b1, 8'h11, 1'b1, 8'h11},
        {1'b1, 8'h22, 1'b1, 1'b1, 8'h22, 1'b0, 8'h00},  // R2 / R3 coincident
        {1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 8'h22},  // R3 deferred fire
        {1'b1, 8'h33, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00},
        {1'b1, 8'h44, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00},
        {1'b1, 8'h55, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00},
        {1'b0, 8'h00, 1'b1, 1'b1, 8'h55, 1'b1, 8'h55},  // R4 last wins
        {1'b1, 8'h66, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00},
        {1'b1, 8'h77, 1'b1, 1'b1, 8'h77, 1'b1, 8'h66},  // R6 pending + coincident
        {1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 8'h77},  // R6 re-armed fire
        {1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00},  // R5 drained
        {1'b1, 8'h88, 1'b1, 1'b1, 8'h88, 1'b0, 8'h00},
        {1'b0, 8'h00, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00},  // R1 no sample, no out
        {1'b0, 8'h00, 1'b1, 1'b0, 8'h00, 1'b1, 8'h88}
    };

    task automatic check(input string req, input logic av, input logic [DW-1:0] ad,
                         input logic ev, input logic [DW-1:0] ed);
        checks++;
        if (av !== ev || ad !== ed) begin
            failures++;
            $display("FAIL %s: got vld=%0b data=%02h, expected vld=%0b data=%02h",
                     req, av, ad, ev, ed);
        end
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Drive one cycle at the falling edge and sample mid low phase.
    task automatic drive(input logic iv, input logic [DW-1:0] id, input logic sv);
        @(negedge clk);
        in_vld  = iv;
        in_data = id;
        smp_vld = sv;
        #5;
    endtask

    initial begin
        #(20 * 5000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: got running, expected finished");
            finish_run();
        end
    end

    initial begin
        // Reset state (R8, R7)
        repeat (3) @(negedge clk);
        #5;
        check("R7 reset weak", w_vld, w_data, 1'b0, 8'h00);
        check("R7 reset strict", s_vld, s_data, 1'b0, 8'h00);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector walk (R1..R7)
        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][27], VEC[i][26:19], VEC[i][18]);
            check($sformatf("R1-vec%0d weak", i), w_vld, w_data, VEC[i][17], VEC[i][16:9]);
            check($sformatf("R1-vec%0d strict", i), s_vld, s_data, VEC[i][8], VEC[i][7:0]);
        end

        // R8: pending input then reset, then a lone sample gives nothing
        drive(1'b1, 8'h99, 1'b0);
        @(negedge clk);
        in_vld = 1'b0;
        rst_n  = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        drive(1'b0, 8'h00, 1'b1);
        check("R8 weak after reset", w_vld, w_data, 1'b0, 8'h00);
        check("R8 strict after reset", s_vld, s_data, 1'b0, 8'h00);

        // R2 / R3: coincident input on an idle block, in both modes
        drive(1'b1, 8'hA5, 1'b1);
        check("R2 weak coincident", w_vld, w_data, 1'b1, 8'hA5);
        check("R3 strict coincident", s_vld, s_data, 1'b0, 8'h00);
        drive(1'b0, 8'h00, 1'b1);
        check("R3 strict next sample", s_vld, s_data, 1'b1, 8'hA5);
        check("R5 weak next sample", w_vld, w_data, 1'b0, 8'h00);

        drive(1'b0, 8'h00, 1'b0);
        done = 1'b1;
        finish_run();
    end

endmodule